// File: doc/BRIEF.md
# Two-Wire EEPROM Slave Controller

This block is the slave side of a two-wire serial memory. It holds a 128-byte array in registers and exposes it over a clock line and an open-drain data line. Both lines are sampled with a fast system clock. The block detects START and STOP conditions and checks the device type in the first byte. It supports four transfers: writing a single byte or a page of up to 8 bytes, reading at the current pointer, reading at a chosen address, and reading any number of bytes in a row.

Write data collects in a page buffer. It reaches the array only when a STOP closes the command and the write-enable input is high at that moment. A self-timed write cycle then runs for a parameterised number of system clocks and shows on `busy`. During that cycle the slave acknowledges nothing, so a master can find the end of the cycle by polling with address bytes.

Top module: `tw_eeprom`

## Requirements
- R1: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. Before the first START, clocked bits get no response and the slave never pulls SDA low.
- R2: The first byte after START is acknowledged only when its bits 7..4 equal 1010. Bits 3..1 are don't-care, and bit 0 selects the direction: 1 is read, 0 is write. Any other type code gets a NACK.
- R3: The slave changes SDA only while SCL is low. Its ACK and its read data stay stable for the whole SCL high time.
- R4: A byte write is the device byte with bit 0 = 0, then a word address (bits 6..0 used), then one data byte, then STOP. It stores that byte at that address.
- R5: Within a write, the low 3 address bits advance after each data byte and wrap from 7 to 0, while bits 6..3 stay fixed. A 9th or later byte overwrites an earlier byte of the same 8-byte page.
- R6: Buffered bytes are committed only by the STOP that ends the write. A START that arrives before that STOP discards them.
- R7: When `wr_en` is low at the STOP, nothing is written and no write cycle starts. Lowering `wr_en` after the STOP does not stop the committed write.
- R8: The STOP of a committing write raises `busy` for WR_CYCLES system clocks. While `busy` is high, every device byte gets a NACK; after it falls, ACKs resume.
- R9: After a write whose last data byte went to address n, a current read returns address n. After a read of address n, it returns n+1.
- R10: In a sequential read, the address advances over all 7 bits and wraps from 7Fh to 00h. A master NACK makes the slave release SDA and send nothing more.
- R11: A random read is a write command that carries only a word address, then a repeated START and a device byte with bit 0 = 1. It returns data starting at that address.
- R12: After reset every array location reads FFh, `busy` is low and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | Pull SDA low when 1 (open-drain drive) |
| wr_en | input | 1 | Write enable, sampled at the committing STOP |
| busy | output | 1 | Internal write cycle in progress |

## Verification
Two situations are hard to reach from the pins. The first is a START that arrives between data bytes and the STOP of a write. The bench forces it with a repeated START placed after a data byte and before the STOP, then reads the location back unchanged. The second is the polling window, which the bench hits by sending a device byte right after a committing STOP, while `busy` is still high. Page wrap and pointer wrap are covered by a 10-byte page write and by a sweep that writes all 16 pages and reads the array back in one sequential read that crosses 7Fh.

// File: rtl/tw_eeprom.sv
module tw_eeprom #(
  parameter int WR_CYCLES = 2000,
  parameter int ADDR_W    = 7,
  parameter int PAGE_W    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe,
  input  logic wr_en,
  output logic busy
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PSIZE = 1 << PAGE_W;
  localparam int BW    = $clog2(WR_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_WA, S_WD, S_ACK, S_RD, S_RACK} st_t;

  logic [1:0] scl_sy, sda_sy;
  logic scl_p, sda_p;
  st_t st, nxt;
  logic [3:0] cnt;
  logic [7:0] sr, obyte;
  logic mack;
  logic [ADDR_W-1:0] addr, wptr;
  logic [PSIZE-1:0] pmask;
  logic [7:0] pbuf [PSIZE];
  logic [7:0] mem [DEPTH];
  logic [BW-1:0] bcnt;

  wire scl_s  = scl_sy[1];
  wire sda_s  = sda_sy[1];
  wire start_det = scl_s & scl_p & sda_p & ~sda_s;
  wire stop_det  = scl_s & scl_p & ~sda_p & sda_s;
  wire rise = scl_s & ~scl_p;
  wire fall = ~scl_s & scl_p;
  wire dev_ok = (sr[7:4] == 4'b1010) && (bcnt == '0);
  wire commit = stop_det & wr_en & (|pmask);
  wire byte_end = fall && (cnt == 4'd8);
  wire wd_take = (st == S_WD) && byte_end && !start_det && !stop_det;
  wire [ADDR_W-1:0] wnext = {wptr[ADDR_W-1:PAGE_W], wptr[PAGE_W-1:0] + 1'b1};

  assign busy = (bcnt != '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11; sda_sy <= 2'b11; scl_p <= 1'b1; sda_p <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i}; sda_sy <= {sda_sy[0], sda_i};
      scl_p  <= scl_sy[1];          sda_p  <= sda_sy[1];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; nxt <= S_IDLE; cnt <= '0; sr <= '0; obyte <= '0; mack <= 1'b0;
      sda_oe <= 1'b0; addr <= '0; wptr <= '0; pmask <= '0; bcnt <= '0;
    end else begin
      if (busy) bcnt <= bcnt - 1'b1;
      if (start_det) begin
        st <= S_DEV; cnt <= '0; sda_oe <= 1'b0; pmask <= '0;
      end else if (stop_det) begin
        st <= S_IDLE; sda_oe <= 1'b0; pmask <= '0;
        if (commit) bcnt <= BW'(WR_CYCLES);
      end else begin
        case (st)
          S_DEV, S_WA, S_WD:
            if (rise && cnt < 4'd8) begin
              sr <= {sr[6:0], sda_s}; cnt <= cnt + 1'b1;
            end else if (byte_end) begin
              cnt <= '0;
              if (st == S_DEV) begin
                if (dev_ok) begin
                  sda_oe <= 1'b1; st <= S_ACK; nxt <= sr[0] ? S_RD : S_WA;
                end else st <= S_IDLE;
              end else if (st == S_WA) begin
                sda_oe <= 1'b1; st <= S_ACK; nxt <= S_WD;
                addr <= sr[ADDR_W-1:0]; wptr <= sr[ADDR_W-1:0];
              end else begin
                sda_oe <= 1'b1; st <= S_ACK; nxt <= S_WD;
                pmask[wptr[PAGE_W-1:0]] <= 1'b1; addr <= wptr; wptr <= wnext;
              end
            end
          S_ACK:
            if (fall) begin
              sda_oe <= 1'b0; cnt <= '0; st <= nxt;
              if (nxt == S_RD) begin
                obyte <= mem[addr]; sda_oe <= ~mem[addr][7]; addr <= addr + 1'b1;
              end
            end
          S_RD:
            if (fall) begin
              cnt <= cnt + 1'b1;
              if (cnt == 4'd7) begin
                sda_oe <= 1'b0; st <= S_RACK;
              end else begin
                obyte <= {obyte[6:0], 1'b0}; sda_oe <= ~obyte[6];
              end
            end
          S_RACK:
            if (rise) mack <= ~sda_s;
            else if (fall) begin
              cnt <= '0;
              if (mack) begin
                st <= S_RD; obyte <= mem[addr]; sda_oe <= ~mem[addr][7]; addr <= addr + 1'b1;
              end else st <= S_IDLE;
            end
          default: ;
        endcase
      end
    end

  always_ff @(posedge clk)
    if (wd_take) pbuf[wptr[PAGE_W-1:0]] <= sr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (commit) begin
      for (int i = 0; i < PSIZE; i++)
        if (pmask[i]) mem[{wptr[ADDR_W-1:PAGE_W], PAGE_W'(i)}] <= pbuf[i];
    end
endmodule

// File: rtl/tw_eeprom_chk.sv
module tw_eeprom_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic sda_oe,
  input logic busy,
  input logic stop_det,
  input logic wr_en
);
  a_r3_drive_while_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_s);
  a_r8_busy_starts_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_det));
  a_r7_no_cycle_when_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det && !wr_en && !busy) |=> !busy);
  a_r8_silent_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe);
endmodule

bind tw_eeprom tw_eeprom_chk chk_i (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_sy[1]), .sda_oe(sda_oe),
  .busy(busy), .stop_det(stop_det), .wr_en(wr_en)
);

// File: tb/tw_eeprom_tb.sv
module tw_eeprom_tb_top;
  localparam int WRC = 300;
  localparam int Q   = 5;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_low = 1'b0, wr_en = 1'b1;
  logic sda_oe, busy;
  wire sda_bus = ~(m_low | sda_oe);

  always #2 clk = ~clk;

  tw_eeprom #(.WR_CYCLES(WRC)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_oe(sda_oe), .wr_en(wr_en), .busy(busy)
  );

  int nchk = 0, nerr = 0, glitch = 0;
  bit done = 1'b0, all_ack, watch = 1'b0, saw_drive = 1'b0;
  logic [7:0] model [128];
  logic [7:0] wbuf [16];
  logic [7:0] rbuf [128];

  always @(negedge clk) if (watch && sda_oe) saw_drive = 1'b1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i_start;
    scl = 0; tick(Q); m_low = 0; tick(Q); scl = 1; tick(Q); m_low = 1; tick(Q); scl = 0; tick(Q);
  endtask

  task automatic i_stop;
    scl = 0; m_low = 1; tick(Q); scl = 1; tick(Q); m_low = 0; tick(Q);
  endtask

  task automatic put_bit(input logic b);
    m_low = ~b; tick(Q); scl = 1; tick(2 * Q); scl = 0; tick(Q);
  endtask

  task automatic get_bit(output logic b);
    logic b2;
    m_low = 0; tick(Q); scl = 1; tick(Q); b = sda_bus; tick(Q - 1); b2 = sda_bus;
    if (b2 !== b) glitch++;
    tick(1); scl = 0; tick(Q);
  endtask

  task automatic wr_byte(input logic [7:0] d, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(a);
    ack = ~a;
  endtask

  task automatic rd_byte(output logic [7:0] d, input logic give_ack);
    for (int i = 7; i >= 0; i--) get_bit(d[i]);
    put_bit(~give_ack);
  endtask

  task automatic pg_write(input logic [6:0] a, input int n);
    logic ack;
    i_start;
    wr_byte(8'hAE, ack); all_ack &= ack;
    wr_byte({1'b0, a}, ack); all_ack &= ack;
    for (int i = 0; i < n; i++) begin wr_byte(wbuf[i], ack); all_ack &= ack; end
    i_stop;
  endtask

  task automatic rnd_read(input logic [6:0] a, input int n);
    logic ack;
    i_start;
    wr_byte(8'hA0, ack); all_ack &= ack;
    wr_byte({1'b1, a}, ack); all_ack &= ack;
    i_start;
    wr_byte(8'hA5, ack); all_ack &= ack;
    for (int i = 0; i < n; i++) rd_byte(rbuf[i], i != n - 1);
    i_stop;
  endtask

  task automatic cur_read(output logic [7:0] d);
    logic ack;
    i_start;
    wr_byte(8'hAB, ack); all_ack &= ack;
    rd_byte(d, 1'b0);
    i_stop;
  endtask

  task automatic wait_idle;
    while (busy) tick(1);
    tick(2);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] d;
    int cyc;
    for (int i = 0; i < 128; i++) model[i] = 8'hFF;
    tick(5); rst_n = 1; tick(5);

    chk(sda_oe == 0 && busy == 0, "R12 reset outputs", {sda_oe, busy}, 0);

    // R1: bits without a START are ignored
    watch = 1; saw_drive = 0;
    scl = 0; tick(Q);
    wr_byte(8'hA0, ack);
    scl = 1; m_low = 0; tick(Q);
    watch = 0;
    chk(!saw_drive && !ack, "R1 no drive before START", saw_drive, 0);

    // R12 / R11: fresh array reads FFh
    all_ack = 1; rnd_read(7'h05, 2);
    chk(all_ack && rbuf[0] == 8'hFF && rbuf[1] == 8'hFF, "R12 R11 initial FFh", rbuf[0], 8'hFF);

    // R2: wrong type codes
    i_start; wr_byte(8'hB0, ack); i_stop;
    chk(!ack, "R2 type 1011 NACK", ack, 0);
    i_start; wr_byte(8'h21, ack); i_stop;
    chk(!ack, "R2 type 0010 NACK", ack, 0);

    // R4 / R8: byte write, busy, polling
    all_ack = 1; wbuf[0] = 8'h5A; pg_write(7'h10, 1); model[8'h10] = 8'h5A;
    chk(all_ack, "R4 byte write acked", all_ack, 1);
    chk(busy == 1, "R8 busy after STOP", busy, 1);
    i_start; wr_byte(8'hA0, ack); i_stop;
    chk(!ack, "R8 NACK while busy", ack, 0);
    cyc = 0;
    while (busy) begin tick(1); cyc++; end
    chk(cyc > WRC - 260 && cyc <= WRC, "R8 write cycle length", cyc, WRC);
    tick(2);
    i_start; wr_byte(8'hA0, ack); i_stop;
    chk(ack, "R8 ACK after cycle", ack, 1);

    // R9: pointer rules
    all_ack = 1; cur_read(d);
    chk(all_ack && d == 8'h5A, "R9 current read after write", d, 8'h5A);
    cur_read(d);
    chk(d == model[8'h11], "R9 current read after read", d, model[8'h11]);

    // R5: page wrap with 10 bytes from 23h
    for (int k = 0; k < 10; k++) begin
      wbuf[k] = 8'h40 + 8'(k);
      model[8'h20 | ((3 + k) & 7)] = wbuf[k];
    end
    all_ack = 1; pg_write(7'h23, 10); wait_idle;
    cur_read(d);
    chk(d == model[8'h20 | ((3 + 9) & 7)], "R9 current read after page write", d, model[8'h24]);
    rnd_read(7'h20, 9);
    for (int i = 0; i < 9; i++)
      chk(rbuf[i] == model[8'h20 + i], "R5 page wrap contents", rbuf[i], model[8'h20 + i]);

    // R7: write-protect
    wr_en = 0; wbuf[0] = 8'h11; pg_write(7'h30, 1);
    chk(busy == 0, "R7 no cycle when wr_en low", busy, 0);
    wr_en = 1;
    rnd_read(7'h30, 1);
    chk(rbuf[0] == model[8'h30], "R7 location unchanged", rbuf[0], model[8'h30]);
    wbuf[0] = 8'h77; pg_write(7'h31, 1); wr_en = 0; model[8'h31] = 8'h77;
    wait_idle; wr_en = 1;
    rnd_read(7'h31, 1);
    chk(rbuf[0] == 8'h77, "R7 dropping wr_en keeps write", rbuf[0], 8'h77);

    // R6: START before STOP cancels
    i_start; wr_byte(8'hA0, ack); wr_byte(8'h32, ack); wr_byte(8'h99, ack);
    i_start; i_stop;
    chk(busy == 0, "R6 cancelled write starts no cycle", busy, 0);
    rnd_read(7'h32, 1);
    chk(rbuf[0] == model[8'h32], "R6 cancelled data not stored", rbuf[0], model[8'h32]);

    // R10: wrap at 7Fh, master NACK ends output
    wbuf[0] = 8'hE1; wbuf[1] = 8'hE2; pg_write(7'h7E, 2); wait_idle;
    wbuf[0] = 8'hD0; wbuf[1] = 8'hD1; pg_write(7'h00, 2); wait_idle;
    model[8'h7E] = 8'hE1; model[8'h7F] = 8'hE2; model[0] = 8'hD0; model[1] = 8'hD1;
    rnd_read(7'h7E, 4);
    for (int i = 0; i < 4; i++)
      chk(rbuf[i] == model[(8'h7E + i) & 8'h7F], "R10 wrap 7Fh to 00h", rbuf[i], model[(8'h7E + i) & 8'h7F]);
    chk(sda_oe == 0, "R10 released after master NACK", sda_oe, 0);

    // sweep: every page, then one sequential read of the whole array
    all_ack = 1;
    for (int p = 0; p < 16; p++) begin
      for (int k = 0; k < 8; k++) begin
        wbuf[k] = 8'((p * 8 + k) * 37 + 11);
        model[p * 8 + k] = wbuf[k];
      end
      pg_write(7'(p * 8), 8); wait_idle;
    end
    rnd_read(7'h00, 128);
    chk(all_ack, "R11 sweep acks", all_ack, 1);
    for (int i = 0; i < 128; i++)
      chk(rbuf[i] == model[i], "R10 R4 sweep data", rbuf[i], model[i]);
    cur_read(d);
    chk(d == model[0], "R9 R10 pointer wrapped to 00h", d, model[0]);

    chk(glitch == 0, "R3 SDA stable while SCL high", glitch, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule